// File: doc/BRIEF.md
# Storage Clock Divider with Oscillator Fallback

This block produces the working clock for a storage-card controller. It divides one of two source clocks by an integer: either a general-purpose PLL clock or a fixed reference oscillator (24 MHz by default). The controller that receives the clock halves it internally. For that reason the divisor is worked out against half the source rate, so the final card clock does not exceed the frequency that was asked for.

Software-side logic issues a request strobe carrying the wanted frequency and the current PLL frequency. A small sequential calculator first tries the PLL. If the PLL divisor would need more than 128 steps, it switches to the oscillator. It then commits the divider field and the source select, and computes the effective rate as a readback value. The calculator runs in the oscillator domain.

The divided clock runs in the domain of whichever source is selected. A new divisor takes effect only at the end of the current output period. A change of source passes through a two-flop enable handshake, so neither source is ever gated through while the other is still active.

Top module: `stor_clk_div`

## Requirements
- R1: The period of `clkOut` is (`divField`+1) periods of the selected source clock.
- R2: With N = `divField`+1 and N of 2 or more, `clkOut` stays high for ceil(N/2) source periods and low for floor(N/2). With N = 1, `clkOut` follows the source clock.
- R3: For a nonzero request, d = ceil(floor(`pllHz`/2) / `reqHz`). If d is at most 128, the PLL is selected (`srcIsOsc` = 0) and `divField` = d-1. A d of 0 is raised to 1.
- R4: If the PLL divisor d exceeds 128, the oscillator is selected (`srcIsOsc` = 1) with d = ceil(floor(OSC_HZ/2) / `reqHz`).
- R5: An oscillator divisor above 128 is clamped to 128 (`divField` = 127).
- R6: When `done` pulses, `rateHz` = floor(src / (`divField`+1)). Here src is OSC_HZ when `srcIsOsc` is 1, and otherwise the `pllHz` given with that request.
- R7: A request with `reqHz` = 0 sets `reqErr`, pulses `done`, and leaves `divField`, `srcIsOsc`, `rateHz` and `clkOut` unchanged. The next nonzero request clears `reqErr`.
- R8: A `reqValid` that arrives while a calculation is in progress is ignored: it produces no extra `done`, and the results are those of the first request.
- R9: `clkOut` never has a high or low phase shorter than half a period of the faster source, including across source switches and divisor changes. The two source enables are never active together.
- R10: After reset, `srcIsOsc`, `divField`, `rateHz`, `reqErr` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkPll | input | 1 | General PLL source clock |
| clkOsc | input | 1 | Oscillator source clock; also clocks the calculator |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe (clkOsc domain) |
| reqHz | input | 32 | Requested card frequency in Hz |
| pllHz | input | 32 | Current general PLL frequency in Hz |
| clkOut | output | 1 | Divided clock to the storage controller |
| done | output | 1 | One-cycle pulse when a request has been handled |
| rateHz | output | 32 | Effective divided rate in Hz |
| srcIsOsc | output | 1 | 1 when the oscillator is the selected source |
| divField | output | 7 | Committed divider field (divisor minus one) |
| reqErr | output | 1 | Set by a zero-frequency request |

## Verification
The hardest behaviour to reach from the ports is the handover between clock domains. A divisor change has to wait out a long output period that is already in progress. A source switch has to stop one clock's enable before the other starts. The stimulus walks a sequence that moves PLL to oscillator and back, enters and leaves the divide-by-one bypass, and jumps from the largest divisor (128) to a small one. Throughout the run a monitor measures every high and low phase of `clkOut`, looking for runts. Requests chosen to land exactly on either side of the 128 threshold check the fallback decision at its boundary. A second strobe sent in the middle of a calculation checks that it is dropped.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  parameter int FIELD_W = 7;
  parameter int MAX_DIV = 2 ** FIELD_W;

  // strobes and settings handed from the calculator to the datapath
  typedef struct packed {
    logic                applyTgl;
    logic                useOsc;
    logic [FIELD_W-1:0]  field;
  } cdivCfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PLL, ST_OSC, ST_RATE} ctrlState_e;
endpackage

// File: rtl/cdiv_seqdiv.sv
`timescale 1ns/1ps
module cdiv_seqdiv #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);
  localparam int PW = 2 * W;

  logic [W-1:0]  rem, numL, denL;
  logic [W:0]    remS;
  logic [CW-1:0] cnt;
  logic          busy;

  always_comb remS = {rem, quo[W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      numL <= '0;
      denL <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo  <= num;
        rem  <= '0;
        numL <= num;
        denL <= den;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (remS >= {1'b0, denL}) begin
          rem <= W'(remS - {1'b0, denL});
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= remS[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // floor-division result is exact: q*d <= n < (q+1)*d (basis of R3..R6)
  assert_quotient_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && denL != '0) |->
      ((PW'(quo) * PW'(denL) <= PW'(numL)) &&
       (PW'(numL) - PW'(quo) * PW'(denL) < PW'(denL))));
endmodule

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int HZ_W   = 32,
  parameter int OSC_HZ = 24_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [HZ_W-1:0] reqHz,
  input  logic [HZ_W-1:0] pllHz,
  output cdivCfg_t        cfg,
  output logic            done,
  output logic [HZ_W-1:0] rateHz,
  output logic            reqErr
);
  localparam int DW = HZ_W + 1;
  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] OSC_D    = DW'(OSC_HZ);
  localparam logic [DW-1:0] HALF_OSC = DW'(OSC_HZ / 2);
  localparam logic [DW-1:0] MAXD     = DW'(MAX_DIV);

  ctrlState_e      state;
  logic [HZ_W-1:0] reqL, pllL;
  logic            divStart, divDone;
  logic [DW-1:0]   divNum, divDen, divQuo, clampDv;
  logic            fallNow, commitNow;

  cdiv_seqdiv #(.W(DW)) uDiv (
    .clk(clk), .rst_n(rst_n), .start(divStart),
    .num(divNum), .den(divDen), .done(divDone), .quo(divQuo)
  );

  always_comb begin
    if (divQuo > MAXD)        clampDv = MAXD;
    else if (divQuo == '0)    clampDv = DW'(1);
    else                      clampDv = divQuo;
    fallNow   = divDone && (state == ST_PLL) && (divQuo > MAXD);
    commitNow = divDone && ((state == ST_OSC) ||
                            ((state == ST_PLL) && (divQuo <= MAXD)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg      <= '0;
      done     <= 1'b0;
      rateHz   <= '0;
      reqErr   <= 1'b0;
      reqL     <= '0;
      pllL     <= '0;
      divStart <= 1'b0;
      divNum   <= '0;
      divDen   <= '0;
    end else begin
      divStart <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          if (reqHz == '0) begin
            reqErr <= 1'b1;
            done   <= 1'b1;
          end else begin
            reqErr   <= 1'b0;
            reqL     <= reqHz;
            pllL     <= pllHz;
            divNum   <= ({1'b0, pllHz} >> 1) + {1'b0, reqHz} - DW'(1);
            divDen   <= {1'b0, reqHz};
            divStart <= 1'b1;
            state    <= ST_PLL;
          end
        end
        ST_PLL, ST_OSC: begin
          if (fallNow) begin
            divNum   <= HALF_OSC + {1'b0, reqL} - DW'(1);
            divDen   <= {1'b0, reqL};
            divStart <= 1'b1;
            state    <= ST_OSC;
          end else if (commitNow) begin
            cfg.field    <= FIELD_W'(clampDv - DW'(1));
            cfg.useOsc   <= (state == ST_OSC);
            cfg.applyTgl <= ~cfg.applyTgl;
            divNum       <= (state == ST_OSC) ? OSC_D : {1'b0, pllL};
            divDen       <= clampDv;
            divStart     <= 1'b1;
            state        <= ST_RATE;
          end
        end
        ST_RATE: if (divDone) begin
          rateHz <= divQuo[HZ_W-1:0];
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // readback relation between committed field, source and rate
  logic [PW-1:0] srcW, dvW, prodW;
  always_comb begin
    srcW  = cfg.useOsc ? PW'(OSC_HZ) : PW'(pllL);
    dvW   = PW'(cfg.field) + PW'(1);
    prodW = PW'(rateHz) * dvW;
  end

  assert_rate_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reqErr) |-> ((prodW <= srcW) && (srcW - prodW < dvW)));

  assert_fallback_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reqErr) |->
      (cfg.useOsc == ((PW'(pllL) >> 1) > PW'(MAX_DIV) * PW'(reqL))));

  assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && reqValid && reqHz == '0) |=>
      ($stable(cfg) && $stable(rateHz) && reqErr && done));
endmodule

// File: rtl/cdiv_datapath.sv
`timescale 1ns/1ps
module cdiv_datapath
  import cdiv_pkg::*;
(
  input  logic     clkPll,
  input  logic     clkOsc,
  input  logic     rst_n,
  input  cdivCfg_t cfg,
  output logic     clkOut
);
  localparam int HL_W = FIELD_W + 1;

  // glitch-free source selection: arm on rising edge, enable on falling edge
  logic pllS1, enPll, oscS1, enOsc, clkMux;

  always_ff @(posedge clkPll or negedge rst_n)
    if (!rst_n) pllS1 <= 1'b0;
    else        pllS1 <= !cfg.useOsc && !enOsc;

  always_ff @(negedge clkPll or negedge rst_n)
    if (!rst_n) enPll <= 1'b0;
    else        enPll <= pllS1;

  always_ff @(posedge clkOsc or negedge rst_n)
    if (!rst_n) oscS1 <= 1'b0;
    else        oscS1 <= cfg.useOsc && !enPll;

  always_ff @(negedge clkOsc or negedge rst_n)
    if (!rst_n) enOsc <= 1'b0;
    else        enOsc <= oscS1;

  assign clkMux = (clkPll & enPll) | (clkOsc & enOsc);

  // divider in the muxed-clock domain
  logic               tS1, tS2, tS3, tglEdge;
  logic [FIELD_W-1:0] pendField, curField, cnt;
  logic [FIELD_W-1:0] loadField, nf, nextCnt;
  logic [HL_W-1:0]    highLen;
  logic               lastCnt, divReg, bypassQ;

  always_comb begin
    tglEdge   = tS2 ^ tS3;
    loadField = tglEdge ? cfg.field : pendField;
    lastCnt   = (cnt == curField);
    nf        = lastCnt ? loadField : curField;
    nextCnt   = lastCnt ? '0 : cnt + FIELD_W'(1);
    highLen   = ({1'b0, nf} + HL_W'(2)) >> 1;
  end

  always_ff @(posedge clkMux or negedge rst_n) begin
    if (!rst_n) begin
      tS1       <= 1'b0;
      tS2       <= 1'b0;
      tS3       <= 1'b0;
      pendField <= '0;
      curField  <= '0;
      cnt       <= '0;
      divReg    <= 1'b0;
      bypassQ   <= 1'b0;
    end else begin
      tS1 <= cfg.applyTgl;
      tS2 <= tS1;
      tS3 <= tS2;
      if (tglEdge) pendField <= cfg.field;
      if (lastCnt) curField  <= loadField;
      cnt     <= nextCnt;
      divReg  <= (nf != '0) && ({1'b0, nextCnt} < highLen);
      bypassQ <= (nf == '0);
    end
  end

  assign clkOut = divReg | (clkMux & bypassQ);

  assert_single_source_R9: assert property (@(posedge clkOsc) disable iff (!rst_n)
    $onehot0({enPll, enOsc}));

  assert_count_bound_R1: assert property (@(posedge clkMux) disable iff (!rst_n)
    cnt <= curField);
endmodule

// File: rtl/stor_clk_div.sv
`timescale 1ns/1ps
module stor_clk_div
  import cdiv_pkg::*;
#(
  parameter int HZ_W   = 32,
  parameter int OSC_HZ = 24_000_000
) (
  input  logic               clkPll,
  input  logic               clkOsc,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [HZ_W-1:0]    reqHz,
  input  logic [HZ_W-1:0]    pllHz,
  output logic               clkOut,
  output logic               done,
  output logic [HZ_W-1:0]    rateHz,
  output logic               srcIsOsc,
  output logic [FIELD_W-1:0] divField,
  output logic               reqErr
);
  cdivCfg_t cfg;

  cdiv_ctrl #(.HZ_W(HZ_W), .OSC_HZ(OSC_HZ)) uCtrl (
    .clk(clkOsc), .rst_n(rst_n), .reqValid(reqValid), .reqHz(reqHz),
    .pllHz(pllHz), .cfg(cfg), .done(done), .rateHz(rateHz), .reqErr(reqErr)
  );

  cdiv_datapath uDp (
    .clkPll(clkPll), .clkOsc(clkOsc), .rst_n(rst_n), .cfg(cfg), .clkOut(clkOut)
  );

  assign srcIsOsc = cfg.useOsc;
  assign divField = cfg.field;
endmodule

// File: tb/tb_stor_clk_div.sv
`timescale 1ns/1ps
module tb_stor_clk_div;
  logic        clkPll = 1'b0, clkOsc = 1'b0, rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqHz = '0, pllHz = '0;
  logic        clkOut, done, srcIsOsc, reqErr;
  logic [31:0] rateHz;
  logic [6:0]  divField;

  always #5 clkOsc = ~clkOsc;   // 100 MHz control/oscillator clock
  always #3 clkPll = ~clkPll;   // faster PLL stand-in

  stor_clk_div dut (
    .clkPll(clkPll), .clkOsc(clkOsc), .rst_n(rst_n), .reqValid(reqValid),
    .reqHz(reqHz), .pllHz(pllHz), .clkOut(clkOut), .done(done),
    .rateHz(rateHz), .srcIsOsc(srcIsOsc), .divField(divField), .reqErr(reqErr)
  );

  typedef struct {
    bit     osc;
    int     field;
    longint rate;
    bit     err;
    string  tag;
  } exp_t;

  exp_t   sbq[$];
  exp_t   lastExp;
  exp_t   got;
  int     total = 0, failed = 0, extraDone = 0, runts = 0;
  bit     seenEdge = 0;
  longint lastEdge = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  function automatic exp_t predict(longint req, longint pll, string tag);
    exp_t e;
    longint d;
    if (req == 0) begin
      e = lastExp; e.err = 1; e.tag = tag;
      return e;
    end
    d = (pll / 2 + req - 1) / req;
    e.osc = 0;
    if (d > 128) begin
      e.osc = 1;
      d = (12000000 + req - 1) / req;
      if (d > 128) d = 128;
    end
    if (d < 1) d = 1;
    e.field = int'(d - 1);
    e.rate  = (e.osc ? 64'd24000000 : pll) / d;
    e.err   = 0;
    e.tag   = tag;
    return e;
  endfunction

  // driver: predict, push to scoreboard, strobe, wait until the monitor drains it
  task automatic request(input longint req, input longint pll, input string tag);
    exp_t e;
    e = predict(req, pll, tag);
    sbq.push_back(e);
    lastExp = e;
    @(negedge clkOsc);
    reqValid = 1'b1; reqHz = 32'(req); pllHz = 32'(pll);
    @(negedge clkOsc);
    reqValid = 1'b0;
    while (sbq.size() != 0) @(negedge clkOsc);
  endtask

  // monitor: compare outputs in the cycle done is high
  always @(negedge clkOsc) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) extraDone++;
      else begin
        got = sbq.pop_front();
        chk(divField == 7'(got.field), {got.tag, " field"}, divField, got.field);
        chk(srcIsOsc == got.osc, {got.tag, " source"}, srcIsOsc, got.osc);
        chk(rateHz == 32'(got.rate), {got.tag, " R6 rate"}, rateHz, got.rate);
        chk(reqErr == got.err, {got.tag, " error flag"}, reqErr, got.err);
      end
    end
  end

  // runt detector on every output phase (R9)
  always @(clkOut) begin
    if (rst_n) begin
      if (seenEdge && ($time - lastEdge) < 3) runts++;
      seenEdge = 1;
      lastEdge = $time;
    end
  end

  // R1 period and R2 high phase, after the new setting has settled
  task automatic checkWave(input string tag);
    longint t0, t1, t2, tsrc, n, per, hi;
    repeat (400) @(negedge clkOsc);
    tsrc = lastExp.osc ? 10 : 6;
    n    = lastExp.field + 1;
    per  = tsrc * n;
    hi   = (n == 1) ? tsrc / 2 : ((n + 1) / 2) * tsrc;
    @(posedge clkOut); t0 = $time;
    @(negedge clkOut); t1 = $time;
    @(posedge clkOut); t2 = $time;
    chk((t2 - t0) == per, {tag, " R1 period"}, t2 - t0, per);
    chk((t1 - t0) == hi,  {tag, " R2 high phase"}, t1 - t0, hi);
  endtask

  initial begin
    #1_500_000;
    chk(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    lastExp = '{osc: 0, field: 0, rate: 0, err: 0, tag: "reset"};
    repeat (3) @(negedge clkOsc);
    rst_n = 1'b1;
    @(negedge clkOsc);
    // R10 reset values
    chk(srcIsOsc == 0, "R10 source", srcIsOsc, 0);
    chk(divField == 0, "R10 field", divField, 0);
    chk(rateHz == 0, "R10 rate", rateHz, 0);
    chk(reqErr == 0, "R10 error", reqErr, 0);
    chk(done == 0, "R10 done", done, 0);

    request(50_000_000, 594_000_000, "R3 even pll");      checkWave("R3 even pll");
    request(100_000_000, 594_000_000, "R2 odd pll");      checkWave("R2 odd pll");
    request(1_000_000_000, 594_000_000, "R2 bypass");     checkWave("R2 bypass");
    request(400_000, 594_000_000, "R4 fallback");         checkWave("R4 fallback");
    request(1_000, 594_000_000, "R5 clamp");              checkWave("R5 clamp");
    request(0, 594_000_000, "R7 zero");                   checkWave("R7 zero keeps clock");
    request(2_320_312, 594_000_000, "R4 just over 128");  checkWave("R4 just over 128");
    request(2_320_313, 594_000_000, "R3 exactly 128");    checkWave("R3 exactly 128");

    // R8: a second strobe during the calculation must be dropped
    begin
      exp_t e;
      e = predict(25_000_000, 300_000_000, "R8 busy drop");
      sbq.push_back(e);
      lastExp = e;
      @(negedge clkOsc);
      reqValid = 1'b1; reqHz = 32'd25_000_000; pllHz = 32'd300_000_000;
      @(negedge clkOsc);
      reqValid = 1'b0;
      repeat (5) @(negedge clkOsc);
      reqValid = 1'b1; reqHz = 32'd0;
      @(negedge clkOsc);
      reqValid = 1'b0;
      while (sbq.size() != 0) @(negedge clkOsc);
      repeat (150) @(negedge clkOsc);
    end
    chk(extraDone == 0, "R8 no extra done", extraDone, 0);
    checkWave("R8 busy drop");

    chk(runts == 0, "R9 no runt phases", runts, 0);
    finishRun();
  end
endmodule